// File: doc/BRIEF.md
# Interrupt Trap Entry and Return Sequencer

This block sits beside a processor pipeline and decides when a pending interrupt is taken. It watches a maskable request (a priority level plus a vector number) and a non-maskable source, and acts only when the core reports that an instruction has finished. When it accepts an interrupt it saves the interrupted context on a full-descending 32-bit stack through a simple request/acknowledge memory port, rewrites the status word, moves the stack pointer, reads the handler address from the trap table and hands it to the core as the new program counter.

When the finishing instruction is a return-from-interrupt, the block pops the saved status word and program counter and hands them back in one cycle, together with the restored stack pointer. The non-maskable source is the OR of an active-low pin and a watchdog timeout. It is edge-detected, takes priority over maskable requests, and is held off entirely until the core first reports a completed stack-pointer write after reset.

The core keeps ownership of its status, stack-pointer and program-counter registers. The block reads their current values and writes them through one-cycle strobes.

Top module: `trap_seq`

## Requirements
- R1: A maskable request (`irq_req`, `irq_lvl`, `irq_vec`) is registered every cycle. At an instruction boundary (`insn_done` high while `busy` is low), the decision uses the value registered one cycle earlier. `insn_done` while `busy` is high has no effect.
- R2: A maskable request is accepted only when status bit 4 (interrupt enable) is 1 and `irq_lvl` is strictly greater than the level field in status bits 11:8. On acceptance `irq_ack` pulses for one cycle.
- R3: On entry the block first writes `pc_next` to SP-4, then writes the status word to SP-8. In the cycle that second write completes, it strobes a new status word (bit 4 cleared, bits 11:8 set to the accepted level) and SP-8. It then reads the word at `ttbr` + 4*vector and loads it as the program counter.
- R4: `insn_done` together with `reti_cmd` reads the status word at SP and the program counter at SP+4. In the cycle the second read completes, it strobes the popped status, SP+8 and the popped program counter. At that boundary a return is served before any pending interrupt.
- R5: A non-maskable trap uses vector 7 (table address `ttbr` + 28), ignores the enable bit and the level field, wins over a maskable request at the same boundary, and does not pulse `irq_ack`.
- R6: A non-maskable entry clears status bit 4 but leaves bits 11:8 unchanged.
- R7: After reset, non-maskable events are discarded until the first cycle with `sp_wr_done` high.
- R8: The non-maskable source is `!nmi_pin_n | wdt_tmo`, taken on its rising edge, so a pin held low yields one trap.
- R9: `mem_req` with its address, write flag and data stays stable until the cycle `mem_ack` is high, which completes the transfer.
- R10: A non-maskable edge that arrives while a sequence is running is latched and taken at a later boundary.
- R11: After reset `busy`, `mem_req`, `pc_load`, `psr_wr_en` and `sp_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_done | input | 1 | Instruction completes this cycle |
| reti_cmd | input | 1 | Completing instruction is a return-from-interrupt |
| irq_req | input | 1 | Maskable request present |
| irq_lvl | input | 4 | Priority of the maskable request |
| irq_vec | input | 6 | Vector number of the maskable request |
| nmi_pin_n | input | 1 | Active-low non-maskable pin |
| wdt_tmo | input | 1 | Watchdog timeout, active high |
| sp_wr_done | input | 1 | Core completed a stack-pointer write |
| pc_next | input | 32 | Address of the instruction after the current one |
| sp_in | input | 32 | Current stack pointer |
| psr_in | input | 32 | Current status word |
| ttbr | input | 32 | Trap table base address |
| busy | output | 1 | Entry or return sequence in progress |
| irq_ack | output | 1 | Maskable request accepted this cycle |
| psr_wr_en | output | 1 | Status word write strobe |
| psr_wr_data | output | 32 | Status word to write |
| sp_wr_en | output | 1 | Stack pointer write strobe |
| sp_wr_data | output | 32 | Stack pointer to write |
| pc_load | output | 1 | Program counter load strobe |
| pc_load_addr | output | 32 | Program counter to load |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_addr | output | 32 | Transfer byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Transfer completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The bench raises the request level in the same cycle as the boundary. A design that decides on the live input instead of the registered one would take a trap there. It offers a level equal to the current field, where a design using >= would enter. It also fires a non-maskable pulse before the stack pointer is written, where a design without the gate would trap, and holds the pin low across several boundaries, where a level-sensitive design would trap repeatedly. A non-maskable edge is latched during a running sequence and meets a return at the next boundary. A design with the wrong priority would enter before popping, and a design that dropped the edge would never trap. Memory is stalled on every transfer, so a sequencer that moves its address or skips ahead before the acknowledge is caught.

// File: rtl/trap_pkg.sv
package trap_pkg;

  // Sequencer states for entry and return
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_PC,
    ST_PUSH_SR,
    ST_FETCH_VEC,
    ST_POP_SR,
    ST_POP_PC
  } seq_state_e;

  // Decision taken at an instruction boundary
  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_IRQ,
    ACT_NMI,
    ACT_RET
  } act_e;

endpackage

// File: rtl/trap_nmi_gate.sv
module trap_nmi_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_pin_n,
  input  logic wdt_tmo,
  input  logic sp_wr_done,
  input  logic take_nmi,
  output logic nmi_pend
);

  logic src;
  logic src_q;
  logic rise;
  logic armed_q, armed_d;
  logic pend_q, pend_d;

  // Combined non-maskable source and its rising edge
  assign src  = ~nmi_pin_n | wdt_tmo;
  assign rise = src & ~src_q;

  always_comb begin
    armed_d = armed_q | sp_wr_done;
    pend_d  = pend_q;
    if (take_nmi)
      pend_d = 1'b0;
    if (rise && armed_q)
      pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= 1'b0;
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      src_q   <= src;
      armed_q <= armed_d;
      pend_q  <= pend_d;
    end
  end

  assign nmi_pend = pend_q;

  // R7: nothing becomes pending while the gate is closed
  a_r7_gate_closed: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> !pend_q);

  // R10: a pending event survives until it is taken
  a_r10_pend_held: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !take_nmi |=> pend_q);

endmodule

// File: rtl/trap_accept.sv
module trap_accept #(
  parameter int LVL_W   = 4,
  parameter int VEC_W   = 6,
  parameter int NMI_VEC = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               irq_req,
  input  logic [LVL_W-1:0]   irq_lvl,
  input  logic [VEC_W-1:0]   irq_vec,
  input  logic               insn_done,
  input  logic               reti_cmd,
  input  logic               idle,
  input  logic               ie,
  input  logic [LVL_W-1:0]   cur_lvl,
  input  logic               nmi_pend,
  output trap_pkg::act_e     act,
  output logic [LVL_W-1:0]   acc_lvl,
  output logic [VEC_W-1:0]   acc_vec
);
  import trap_pkg::*;

  logic             req_q;
  logic [LVL_W-1:0] lvl_q;
  logic [VEC_W-1:0] vec_q;
  logic             boundary;
  logic             irq_ok;

  // Per-cycle sampling of the maskable request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      lvl_q <= '0;
      vec_q <= '0;
    end else begin
      req_q <= irq_req;
      lvl_q <= irq_lvl;
      vec_q <= irq_vec;
    end
  end

  assign boundary = insn_done & idle;
  assign irq_ok   = req_q & ie & (lvl_q > cur_lvl);

  // Priority: return, then non-maskable, then maskable
  always_comb begin
    act = ACT_NONE;
    if (boundary) begin
      if (reti_cmd)
        act = ACT_RET;
      else if (nmi_pend)
        act = ACT_NMI;
      else if (irq_ok)
        act = ACT_IRQ;
    end
  end

  assign acc_lvl = lvl_q;
  assign acc_vec = (act == ACT_NMI) ? VEC_W'(NMI_VEC) : vec_q;

endmodule

// File: rtl/trap_fsm.sv
module trap_fsm #(
  parameter int DW     = 32,
  parameter int LVL_W  = 4,
  parameter int VEC_W  = 6,
  parameter int IE_BIT = 4,
  parameter int IL_LSB = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  trap_pkg::act_e     act,
  input  logic [LVL_W-1:0]   acc_lvl,
  input  logic [VEC_W-1:0]   acc_vec,
  input  logic [DW-1:0]      pc_next,
  input  logic [DW-1:0]      sp_in,
  input  logic [DW-1:0]      psr_in,
  input  logic [DW-1:0]      ttbr,
  output logic               busy,
  output logic               psr_wr_en,
  output logic [DW-1:0]      psr_wr_data,
  output logic               sp_wr_en,
  output logic [DW-1:0]      sp_wr_data,
  output logic               pc_load,
  output logic [DW-1:0]      pc_load_addr,
  output logic               mem_req,
  output logic               mem_we,
  output logic [DW-1:0]      mem_addr,
  output logic [DW-1:0]      mem_wdata,
  input  logic               mem_ack,
  input  logic [DW-1:0]      mem_rdata
);
  import trap_pkg::*;

  localparam logic [DW-1:0] WORD  = DW'(4);
  localparam logic [DW-1:0] FRAME = DW'(8);

  seq_state_e       state_q, state_d;
  logic [DW-1:0]    sp_q, sp_d;
  logic [DW-1:0]    pc_q, pc_d;
  logic [DW-1:0]    sr_q, sr_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             nmi_q, nmi_d;
  logic             cap_en;
  logic [DW-1:0]    entry_sr;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    sp_d    = sp_q;
    pc_d    = pc_q;
    sr_d    = sr_q;
    lvl_d   = lvl_q;
    vec_d   = vec_q;
    nmi_d   = nmi_q;
    unique case (state_q)
      ST_IDLE: begin
        if (act == ACT_IRQ || act == ACT_NMI) begin
          state_d = ST_PUSH_PC;
          sp_d    = sp_in;
          pc_d    = pc_next;
          sr_d    = psr_in;
          lvl_d   = acc_lvl;
          vec_d   = acc_vec;
          nmi_d   = (act == ACT_NMI);
        end else if (act == ACT_RET) begin
          state_d = ST_POP_SR;
          sp_d    = sp_in;
        end
      end
      ST_PUSH_PC:   if (mem_ack) state_d = ST_PUSH_SR;
      ST_PUSH_SR:   if (mem_ack) state_d = ST_FETCH_VEC;
      ST_FETCH_VEC: if (mem_ack) state_d = ST_IDLE;
      ST_POP_SR: begin
        if (mem_ack) begin
          sr_d    = mem_rdata;
          state_d = ST_POP_PC;
        end
      end
      ST_POP_PC:    if (mem_ack) state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  // Context registers load only on capture or pop
  assign cap_en = (state_q == ST_IDLE && act != ACT_NONE) ||
                  (state_q == ST_POP_SR && mem_ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state_q <= ST_IDLE;
    else
      state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q  <= '0;
      pc_q  <= '0;
      sr_q  <= '0;
      lvl_q <= '0;
      vec_q <= '0;
      nmi_q <= 1'b0;
    end else if (cap_en) begin
      sp_q  <= sp_d;
      pc_q  <= pc_d;
      sr_q  <= sr_d;
      lvl_q <= lvl_d;
      vec_q <= vec_d;
      nmi_q <= nmi_d;
    end
  end

  // Status word written on entry
  always_comb begin
    entry_sr         = sr_q;
    entry_sr[IE_BIT] = 1'b0;
    if (!nmi_q)
      entry_sr[IL_LSB +: LVL_W] = lvl_q;
  end

  // Memory port
  always_comb begin
    mem_req   = 1'b1;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state_q)
      ST_PUSH_PC: begin
        mem_we    = 1'b1;
        mem_addr  = sp_q - WORD;
        mem_wdata = pc_q;
      end
      ST_PUSH_SR: begin
        mem_we    = 1'b1;
        mem_addr  = sp_q - FRAME;
        mem_wdata = sr_q;
      end
      ST_FETCH_VEC: mem_addr = ttbr + (DW'(vec_q) << 2);
      ST_POP_SR:    mem_addr = sp_q;
      ST_POP_PC:    mem_addr = sp_q + WORD;
      default:      mem_req  = 1'b0;
    endcase
  end

  // Core register strobes
  assign psr_wr_en    = mem_ack && (state_q == ST_PUSH_SR || state_q == ST_POP_PC);
  assign psr_wr_data  = (state_q == ST_PUSH_SR) ? entry_sr : sr_q;
  assign sp_wr_en     = psr_wr_en;
  assign sp_wr_data   = (state_q == ST_PUSH_SR) ? (sp_q - FRAME) : (sp_q + FRAME);
  assign pc_load      = mem_ack && (state_q == ST_FETCH_VEC || state_q == ST_POP_PC);
  assign pc_load_addr = mem_rdata;
  assign busy         = (state_q != ST_IDLE);

  // R9: a waiting transfer keeps its attributes
  a_r9_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R3: the status push always follows the PC push
  a_r3_push_order: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_PUSH_SR && $past(state_q) != ST_PUSH_SR |-> $past(state_q) == ST_PUSH_PC);

  // R6: non-maskable entry keeps the level field of the saved status
  a_r6_nmi_level_kept: assert property (@(posedge clk) disable iff (!rst_n)
    psr_wr_en && state_q == ST_PUSH_SR && nmi_q |->
      psr_wr_data[IL_LSB +: LVL_W] == sr_q[IL_LSB +: LVL_W]);

  // R4: return restores the stack pointer by one frame
  a_r4_pop_sp: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wr_en && state_q == ST_POP_PC |-> sp_wr_data == mem_addr + WORD);

endmodule

// File: rtl/trap_seq.sv
module trap_seq #(
  parameter int DW      = 32,
  parameter int LVL_W   = 4,
  parameter int VEC_W   = 6,
  parameter int IE_BIT  = 4,
  parameter int IL_LSB  = 8,
  parameter int NMI_VEC = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               insn_done,
  input  logic               reti_cmd,
  input  logic               irq_req,
  input  logic [LVL_W-1:0]   irq_lvl,
  input  logic [VEC_W-1:0]   irq_vec,
  input  logic               nmi_pin_n,
  input  logic               wdt_tmo,
  input  logic               sp_wr_done,
  input  logic [DW-1:0]      pc_next,
  input  logic [DW-1:0]      sp_in,
  input  logic [DW-1:0]      psr_in,
  input  logic [DW-1:0]      ttbr,
  output logic               busy,
  output logic               irq_ack,
  output logic               psr_wr_en,
  output logic [DW-1:0]      psr_wr_data,
  output logic               sp_wr_en,
  output logic [DW-1:0]      sp_wr_data,
  output logic               pc_load,
  output logic [DW-1:0]      pc_load_addr,
  output logic               mem_req,
  output logic               mem_we,
  output logic [DW-1:0]      mem_addr,
  output logic [DW-1:0]      mem_wdata,
  input  logic               mem_ack,
  input  logic [DW-1:0]      mem_rdata
);
  import trap_pkg::*;

  logic [1:0]        rst_pipe;
  logic              rst_n_i;
  logic              nmi_pend;
  act_e              act;
  logic [LVL_W-1:0]  acc_lvl;
  logic [VEC_W-1:0]  acc_vec;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe <= '0;
    else
      rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  trap_nmi_gate u_nmi (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .nmi_pin_n  (nmi_pin_n),
    .wdt_tmo    (wdt_tmo),
    .sp_wr_done (sp_wr_done),
    .take_nmi   (act == ACT_NMI),
    .nmi_pend   (nmi_pend)
  );

  trap_accept #(
    .LVL_W   (LVL_W),
    .VEC_W   (VEC_W),
    .NMI_VEC (NMI_VEC)
  ) u_acc (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .irq_req   (irq_req),
    .irq_lvl   (irq_lvl),
    .irq_vec   (irq_vec),
    .insn_done (insn_done),
    .reti_cmd  (reti_cmd),
    .idle      (~busy),
    .ie        (psr_in[IE_BIT]),
    .cur_lvl   (psr_in[IL_LSB +: LVL_W]),
    .nmi_pend  (nmi_pend),
    .act       (act),
    .acc_lvl   (acc_lvl),
    .acc_vec   (acc_vec)
  );

  trap_fsm #(
    .DW     (DW),
    .LVL_W  (LVL_W),
    .VEC_W  (VEC_W),
    .IE_BIT (IE_BIT),
    .IL_LSB (IL_LSB)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n_i),
    .act          (act),
    .acc_lvl      (acc_lvl),
    .acc_vec      (acc_vec),
    .pc_next      (pc_next),
    .sp_in        (sp_in),
    .psr_in       (psr_in),
    .ttbr         (ttbr),
    .busy         (busy),
    .psr_wr_en    (psr_wr_en),
    .psr_wr_data  (psr_wr_data),
    .sp_wr_en     (sp_wr_en),
    .sp_wr_data   (sp_wr_data),
    .pc_load      (pc_load),
    .pc_load_addr (pc_load_addr),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_ack      (mem_ack),
    .mem_rdata    (mem_rdata)
  );

  assign irq_ack = (act == ACT_IRQ);

  // R1: no sequence starts without an instruction boundary
  a_r1_boundary_only: assert property (@(posedge clk) disable iff (!rst_n_i)
    !busy && !insn_done |=> !busy);

  // R5: a maskable acceptance never overtakes a pending non-maskable event
  a_r5_nmi_first: assert property (@(posedge clk) disable iff (!rst_n_i)
    irq_ack |-> !nmi_pend);

  // R2: acceptance always launches a sequence
  a_r2_ack_starts: assert property (@(posedge clk) disable iff (!rst_n_i)
    irq_ack |=> busy);

endmodule

// File: tb/trap_seq_tb_top.sv
module trap_seq_tb_top;

  localparam int DW = 32;
  localparam int IE_BIT = 4;
  localparam int IL_LSB = 8;
  localparam int K_MW = 0, K_PSR = 1, K_SP = 2, K_PC = 3, K_ACK = 4;

  typedef struct {
    int          kind;
    logic [31:0] addr;
    logic [31:0] data;
    string       req;
  } item_t;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, insn_done, reti_cmd, irq_req, nmi_pin_n, wdt_tmo, sp_wr_done;
  logic [3:0]  irq_lvl;
  logic [5:0]  irq_vec;
  logic [31:0] pc_next, ttbr;
  logic        busy, irq_ack, psr_wr_en, sp_wr_en, pc_load, mem_req, mem_we;
  logic [31:0] psr_wr_data, sp_wr_data, pc_load_addr, mem_addr, mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;

  // Core register model
  logic [31:0] psr_q, sp_q;

  trap_seq dut_i (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .reti_cmd(reti_cmd),
    .irq_req(irq_req), .irq_lvl(irq_lvl), .irq_vec(irq_vec),
    .nmi_pin_n(nmi_pin_n), .wdt_tmo(wdt_tmo), .sp_wr_done(sp_wr_done),
    .pc_next(pc_next), .sp_in(sp_q), .psr_in(psr_q), .ttbr(ttbr),
    .busy(busy), .irq_ack(irq_ack), .psr_wr_en(psr_wr_en), .psr_wr_data(psr_wr_data),
    .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data), .pc_load(pc_load),
    .pc_load_addr(pc_load_addr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  item_t       exp_q[$];
  logic [63:0] frames[$];
  logic [31:0] mem [0:255];
  int          wait_cnt = 0;
  int          mem_stall = 2;
  logic        prev_wait = 1'b0;
  logic [31:0] prev_addr = '0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push_exp(input int kind, input logic [31:0] a, input logic [31:0] d, input string req);
    item_t it;
    it.kind = kind; it.addr = a; it.data = d; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic observe(input int kind, input logic [31:0] a, input logic [31:0] d);
    item_t it;
    n_cmp++;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL unexpected event: actual kind %0d addr %h data %h expected none", kind, a, d);
    end else begin
      it = exp_q.pop_front();
      if (it.kind != kind || it.addr !== a || it.data !== d) begin
        n_bad++;
        $display("FAIL %s: actual kind %0d addr %h data %h expected kind %0d addr %h data %h",
                 it.req, kind, a, d, it.kind, it.addr, it.data);
      end
    end
  endtask

  // Memory with a fixed number of wait cycles per transfer
  always @(posedge clk) begin
    #1;
    if (mem_req && !mem_ack) begin
      if (wait_cnt < mem_stall) wait_cnt++;
      else begin
        wait_cnt  = 0;
        mem_ack   = 1'b1;
        mem_rdata = mem[mem_addr[9:2]];
        if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
      end
    end else begin
      mem_ack = 1'b0;
    end
  end

  // Scoreboard monitor and core register update
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_wait) check("R9 addr hold", mem_addr, prev_addr);
      prev_wait = mem_req && !mem_ack;
      prev_addr = mem_addr;
      if (irq_ack) observe(K_ACK, 32'h0, 32'h0);
      if (mem_req && mem_ack && mem_we) observe(K_MW, mem_addr, mem_wdata);
      if (psr_wr_en) observe(K_PSR, 32'h0, psr_wr_data);
      if (sp_wr_en) observe(K_SP, 32'h0, sp_wr_data);
      if (pc_load) observe(K_PC, 32'h0, pc_load_addr);
      if (psr_wr_en) psr_q = psr_wr_data;
      if (sp_wr_en) sp_q = sp_wr_data;
    end
  end

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic boundary(input logic ret);
    insn_done = 1'b1;
    reti_cmd  = ret;
    tick();
    insn_done = 1'b0;
    reti_cmd  = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy && n < 200) begin
      tick();
      n++;
    end
    tick();
    check({req, " finished"}, {31'd0, busy}, 32'd0);
    check({req, " all events seen"}, exp_q.size(), 32'd0);
  endtask

  function automatic logic [31:0] vec_word(input int v);
    return mem[(ttbr + 32'(v) * 4) >> 2];
  endfunction

  task automatic exp_entry(input string req, input bit nmi, input int lvl, input int vec);
    logic [31:0] sr_new;
    if (!nmi) push_exp(K_ACK, 32'h0, 32'h0, req);
    push_exp(K_MW, sp_q - 4, pc_next, req);
    push_exp(K_MW, sp_q - 8, psr_q, req);
    sr_new = psr_q;
    sr_new[IE_BIT] = 1'b0;
    if (!nmi) sr_new[IL_LSB +: 4] = 4'(lvl);
    push_exp(K_PSR, 32'h0, sr_new, req);
    push_exp(K_SP, 32'h0, sp_q - 8, req);
    push_exp(K_PC, 32'h0, vec_word(nmi ? 7 : vec), req);
    frames.push_back({psr_q, pc_next});
  endtask

  task automatic exp_return(input string req);
    logic [63:0] f;
    f = frames.pop_back();
    push_exp(K_PSR, 32'h0, f[63:32], req);
    push_exp(K_SP, 32'h0, sp_q + 8, req);
    push_exp(K_PC, 32'h0, f[31:0], req);
  endtask

  task automatic expect_idle(input string req);
    tick();
    check(req, {31'd0, busy}, 32'd0);
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 + 32'(i) * 16;
    rst_n = 1'b0; insn_done = 1'b0; reti_cmd = 1'b0; irq_req = 1'b0;
    irq_lvl = '0; irq_vec = '0; nmi_pin_n = 1'b1; wdt_tmo = 1'b0; sp_wr_done = 1'b0;
    pc_next = 32'h0000_4000; ttbr = 32'h0000_0100; mem_ack = 1'b0; mem_rdata = '0;
    psr_q = 32'h0; sp_q = 32'h0000_03F0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R11 reset state
    check("R11 busy", {31'd0, busy}, 32'd0);
    check("R11 mem_req", {31'd0, mem_req}, 32'd0);
    check("R11 strobes", {29'd0, pc_load, psr_wr_en, sp_wr_en}, 32'd0);

    // R7: pulse before the stack pointer is written is discarded
    nmi_pin_n = 1'b0; tick(); nmi_pin_n = 1'b1; tick();
    boundary(1'b0);
    expect_idle("R7 gated before SP write");
    sp_wr_done = 1'b1; tick(); sp_wr_done = 1'b0; tick();
    boundary(1'b0);
    expect_idle("R7 old pulse not replayed");

    // R2: enable bit clear blocks acceptance
    irq_req = 1'b1; irq_lvl = 4'd3; irq_vec = 6'd20; tick();
    boundary(1'b0);
    expect_idle("R2 IE clear");

    // R2: equal level is not accepted
    psr_q = 32'h0000_0310;
    tick();
    boundary(1'b0);
    expect_idle("R2 equal level");

    // R1: level raised in the boundary cycle is not yet seen
    irq_lvl = 4'd5;
    boundary(1'b0);
    expect_idle("R1 late sample");

    // R3: accepted entry, with an ignored boundary while busy
    exp_entry("R3", 1'b0, 5, 20);
    boundary(1'b0);
    boundary(1'b0);
    wait_idle("R3");
    check("R3 level field", psr_q[11:8], 32'd5);
    check("R3 IE cleared", {31'd0, psr_q[IE_BIT]}, 32'd0);
    check("R3 sp", sp_q, 32'h0000_03E8);

    // R4: return restores status and stack pointer
    pc_next = 32'h0000_5000;
    irq_lvl = 4'd7; irq_vec = 6'd21;
    exp_return("R4");
    boundary(1'b1);
    wait_idle("R4");
    check("R4 status restored", psr_q, 32'h0000_0310);
    check("R4 sp restored", sp_q, 32'h0000_03F0);

    // R2: higher level accepted
    pc_next = 32'h0000_4010;
    exp_entry("R2", 1'b0, 7, 21);
    boundary(1'b0);
    wait_idle("R2 higher level");

    // R5/R6: watchdog event wins over an acceptable maskable request
    psr_q = 32'h0000_0710;
    irq_lvl = 4'd9; irq_vec = 6'd22;
    wdt_tmo = 1'b1; tick(); wdt_tmo = 1'b0; tick();
    pc_next = 32'h0000_6000;
    exp_entry("R5", 1'b1, 0, 7);
    boundary(1'b0);
    wait_idle("R5");
    check("R6 level kept", psr_q[11:8], 32'd7);
    check("R6 IE cleared", {31'd0, psr_q[IE_BIT]}, 32'd0);

    exp_return("R4 nmi frame");
    boundary(1'b1);
    wait_idle("R4 nmi frame");

    // R10: pin edge during a running entry is latched
    pc_next = 32'h0000_4020;
    exp_entry("R2 level 9", 1'b0, 9, 22);
    boundary(1'b0);
    nmi_pin_n = 1'b0;
    irq_req = 1'b0;
    wait_idle("R2 level 9");

    // R4: return goes first even with a pending event
    exp_return("R4 before pending");
    boundary(1'b1);
    wait_idle("R4 before pending");

    pc_next = 32'h0000_6100;
    exp_entry("R10", 1'b1, 0, 7);
    boundary(1'b0);
    wait_idle("R10");

    // R8: pin still low gives no second trap
    boundary(1'b0);
    expect_idle("R8 held pin");
    boundary(1'b0);
    expect_idle("R8 held pin again");
    nmi_pin_n = 1'b1;

    exp_return("R4 unwind nmi");
    boundary(1'b1);
    wait_idle("R4 unwind nmi");
    exp_return("R4 unwind base");
    boundary(1'b1);
    wait_idle("R4 unwind base");
    check("R4 final sp", sp_q, 32'h0000_03F0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule